// File: doc/BRIEF.md
# Optical Black Clamp Controller

This block is the digital half of a black-level clamp loop in an image sensor front end. Each pixel clock it sees one 12-bit converter sample and a clamp window input. The window marks the shielded dark pixels at the start of a line. While the window is active, the block forms the signed difference between each sample and a programmable 8-bit target black level, and it sums those differences. When the window closes, the sum is scaled down by a fixed right shift and added to an 8-bit correction code, which saturates at both ends of its range. That code drives an offset DAC at the converter input. The DAC, the converter and the sampling front end sit outside this block.

The correction moves at most once per window, and a divider input can stretch the update to one every N windows for slow tracking. Windows that are too short are thrown away. The window input passes through a polarity select, so either an active-high or an active-low window works. When the loop is turned off, the correction output simply carries the programmed target level as a fixed offset, and the loop stops tracking.

Top module: `black_clamp_loop`

## Requirements
- R1: A synchronous reset sets the correction output to mid-scale (128) and the internal target level to 128.
- R2: A target write (`lvl_we` high) loads `lvl_in` into the target level. While `clamp_en` is low, `dac_code` equals the target level one clock after the target is registered.
- R3: Samples taken while the window is inactive have no effect on `dac_code` or on any later update.
- R4: On the first clock at which the window is seen inactive after an active run, `dac_code` becomes `dac_code + (S >>> 4)`. Here S is the signed sum of (pixel − target) over the window samples, and the shift is arithmetic (it rounds toward minus infinity).
- R5: The updated correction saturates to 0 when the result is negative and to 255 when it exceeds 255.
- R6: A window of fewer than 2 active samples causes no update and adds nothing to any later sum. A window of exactly 2 samples is accepted.
- R7: With `win_pol` = 1 the window is active when `win_in` is high. With `win_pol` = 0 it is active when `win_in` is low.
- R8: With `upd_div` = D, the correction changes only at the end of every (D+1)-th accepted window, by the shifted sum of the errors of all D+1 windows. The windows in between leave `dac_code` unchanged.
- R9: While `clamp_en` is low, the partial sum and the window count are cleared. After it returns high, counting restarts at zero, from the target level.
- R10: While `clamp_en` is high, `dac_code` changes at no time other than an update of R4/R8. A target write while the loop is enabled changes only the reference used for later errors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| pix | input | 12 | Converter sample for this pixel |
| win_in | input | 1 | Clamp window (dark-pixel marker) before the polarity select |
| win_pol | input | 1 | Window polarity: 1 = active high, 0 = active low |
| clamp_en | input | 1 | 1 = loop tracks; 0 = output holds the target as a static offset |
| lvl_we | input | 1 | Target level write strobe |
| lvl_in | input | 8 | New target black level, 0 to 255 LSB of the converter output |
| upd_div | input | 4 | Update every `upd_div`+1 accepted windows |
| dac_code | output | 8 | Correction code to the offset DAC |

## Verification
An update is due on the first rising edge that samples the window inactive. The bench drives inputs on falling edges and reads `dac_code` at the falling edge right after that rising edge, so it compares one register stage after the window closes. After a target write the internal level is valid one edge later, and a disabled loop copies it onto `dac_code` one edge after that. Disable and target-write checks are therefore read two falling edges after the stimulus. Between windows the bench checks on every idle cycle that the output has not moved while out-of-window samples vary.

// File: rtl/obc_pkg.sv
package obc_pkg;

   // Per-cycle view of the clamp window after the polarity select
   typedef struct packed {
      logic act;     // window active this cycle
      logic fin;     // first inactive cycle after an active run
      logic len_ok;  // the run that just ended met the minimum width
   } win_stat_t;

endpackage

// File: rtl/obc_win_track.sv
module obc_win_track
   import obc_pkg::*;
#(
   parameter int MIN_WIN = 2
) (
   input  logic      clk,
   input  logic      rst,
   input  logic      win_in,
   input  logic      win_pol,
   output win_stat_t st
);
   localparam int CNT_W = $clog2(MIN_WIN + 1);
   localparam logic [CNT_W-1:0] CNT_MIN = CNT_W'(MIN_WIN);
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   generate
      if (MIN_WIN < 2) begin : g_bad_min
         $error("obc_win_track: MIN_WIN must be at least 2");
      end
   endgenerate

   logic             act;
   logic             act_q;
   logic [CNT_W-1:0] cnt_q;

   // R7: polarity select
   assign act = win_pol ? win_in : ~win_in;

   always_ff @(posedge clk) begin
      if (rst) begin
         act_q <= 1'b0;
         cnt_q <= '0;
      end else begin
         act_q <= act;
         if (act) begin
            if (!act_q)
               cnt_q <= CNT_ONE;
            else if (cnt_q < CNT_MIN)
               cnt_q <= cnt_q + CNT_ONE;
         end else begin
            cnt_q <= '0;
         end
      end
   end

   assign st.act    = act;
   assign st.fin    = act_q & ~act;
   assign st.len_ok = (cnt_q >= CNT_MIN);

   // R6
   min_width_chk: assert property (@(posedge clk) disable iff (rst)
      (st.fin && st.len_ok) |-> ($past(act, 1) && $past(act, 2)));

endmodule

// File: rtl/obc_accum.sv
module obc_accum
   import obc_pkg::*;
#(
   parameter int PIX_W = 12,
   parameter int LVL_W = 8,
   parameter int ACC_W = 24,
   parameter int DIV_W = 4
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    en,
   input  logic [PIX_W-1:0]        pix,
   input  logic [LVL_W-1:0]        lvl,
   input  win_stat_t               st,
   input  logic [DIV_W-1:0]        upd_div,
   output logic                    fire,
   output logic signed [ACC_W-1:0] total
);
   localparam int ERR_W = PIX_W + 1;
   localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
   localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

   generate
      if (PIX_W <= LVL_W) begin : g_bad_lvl
         $error("obc_accum: PIX_W must exceed LVL_W");
      end
      if (ACC_W < ERR_W + 2) begin : g_bad_acc
         $error("obc_accum: ACC_W too narrow for one error term");
      end
   endgenerate

   function automatic logic signed [ACC_W-1:0] sat_add(
      input logic signed [ACC_W-1:0] a,
      input logic signed [ACC_W-1:0] b
   );
      logic signed [ACC_W:0] s;
      s = $signed({a[ACC_W-1], a}) + $signed({b[ACC_W-1], b});
      if (s[ACC_W] != s[ACC_W-1])
         return s[ACC_W] ? ACC_MIN : ACC_MAX;
      return s[ACC_W-1:0];
   endfunction

   logic signed [ERR_W-1:0] err;
   logic signed [ACC_W-1:0] err_x;
   logic signed [ACC_W-1:0] win_acc;
   logic signed [ACC_W-1:0] span_acc;
   logic [DIV_W-1:0]        n_q;
   logic                    last;
   logic                    take;

   assign err   = $signed({1'b0, pix}) - $signed({{(ERR_W-LVL_W){1'b0}}, lvl});
   assign err_x = {{(ACC_W-ERR_W){err[ERR_W-1]}}, err};
   assign total = sat_add(span_acc, win_acc);
   assign last  = (n_q >= upd_div);
   assign take  = st.fin & st.len_ok;
   assign fire  = en & take & last;

   always_ff @(posedge clk) begin
      if (rst || !en) begin
         win_acc  <= '0;
         span_acc <= '0;
         n_q      <= '0;
      end else begin
         // R3: samples outside the window are never summed
         win_acc <= st.act ? sat_add(win_acc, err_x) : '0;
         if (take) begin
            if (last) begin
               span_acc <= '0;
               n_q      <= '0;
            end else begin
               span_acc <= total;
               n_q      <= n_q + DIV_W'(1);
            end
         end
      end
   end

   // R3
   acc_clear_chk: assert property (@(posedge clk) disable iff (rst)
      st.fin |=> (win_acc == '0));

   // R6
   short_discard_chk: assert property (@(posedge clk) disable iff (rst)
      (en && st.fin && !st.len_ok) |=> $stable(span_acc));

   // R9
   disable_clear_chk: assert property (@(posedge clk) disable iff (rst)
      !en |=> (span_acc == '0 && n_q == '0));

endmodule

// File: rtl/obc_corr.sv
module obc_corr #(
   parameter int LVL_W = 8,
   parameter int DAC_W = 8,
   parameter int ACC_W = 24,
   parameter int SHIFT = 4
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    en,
   input  logic [LVL_W-1:0]        lvl,
   input  logic                    fire,
   input  logic signed [ACC_W-1:0] total,
   output logic [DAC_W-1:0]        code
);
   localparam logic [DAC_W-1:0]      MID   = DAC_W'(1) << (DAC_W - 1);
   localparam logic signed [ACC_W:0] MAX_S = (ACC_W+1)'((1 << DAC_W) - 1);

   generate
      if (LVL_W > DAC_W) begin : g_bad_lvl
         $error("obc_corr: LVL_W must not exceed DAC_W");
      end
      if (ACC_W <= DAC_W + 1) begin : g_bad_acc
         $error("obc_corr: ACC_W must exceed DAC_W + 1");
      end
      if (SHIFT >= ACC_W) begin : g_bad_shift
         $error("obc_corr: SHIFT must be below ACC_W");
      end
   endgenerate

   logic signed [ACC_W-1:0] step;
   logic signed [ACC_W:0]   s;
   logic [DAC_W-1:0]        nxt;
   logic [DAC_W-1:0]        corr_q;

   // Loop filter gain: arithmetic shift of the summed error
   generate
      if (SHIFT == 0) begin : g_noshift
         assign step = total;
      end else begin : g_shift
         assign step = total >>> SHIFT;
      end
   endgenerate

   assign s = $signed({1'b0, {(ACC_W-DAC_W){1'b0}}, corr_q}) + $signed({step[ACC_W-1], step});

   // R5: clamp into the DAC code range
   always_comb begin
      if (s[ACC_W])
         nxt = '0;
      else if (s > MAX_S)
         nxt = '1;
      else
         nxt = s[DAC_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (rst)
         corr_q <= MID;
      else if (!en)
         corr_q <= DAC_W'(lvl);
      else if (fire)
         corr_q <= nxt;
   end

   assign code = corr_q;

   // R10
   corr_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (en && !fire) |=> $stable(corr_q));

   // R2
   disabled_follow_chk: assert property (@(posedge clk) disable iff (rst)
      !en |=> (corr_q == DAC_W'($past(lvl))));

endmodule

// File: rtl/black_clamp_loop.sv
module black_clamp_loop
   import obc_pkg::*;
#(
   parameter int PIX_W   = 12,
   parameter int LVL_W   = 8,
   parameter int DAC_W   = 8,
   parameter int ACC_W   = 24,
   parameter int SHIFT   = 4,
   parameter int MIN_WIN = 2,
   parameter int DIV_W   = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [PIX_W-1:0] pix,
   input  logic             win_in,
   input  logic             win_pol,
   input  logic             clamp_en,
   input  logic             lvl_we,
   input  logic [LVL_W-1:0] lvl_in,
   input  logic [DIV_W-1:0] upd_div,
   output logic [DAC_W-1:0] dac_code
);
   localparam logic [LVL_W-1:0] LVL_RST = LVL_W'(1) << (LVL_W - 1);

   logic [LVL_W-1:0]        lvl_q;
   win_stat_t               st;
   logic                    fire;
   logic signed [ACC_W-1:0] total;

   // R1, R2: target black level register
   always_ff @(posedge clk) begin
      if (rst)
         lvl_q <= LVL_RST;
      else if (lvl_we)
         lvl_q <= lvl_in;
   end

   obc_win_track #(.MIN_WIN(MIN_WIN)) u_win (
      .clk     (clk),
      .rst     (rst),
      .win_in  (win_in),
      .win_pol (win_pol),
      .st      (st)
   );

   obc_accum #(
      .PIX_W (PIX_W),
      .LVL_W (LVL_W),
      .ACC_W (ACC_W),
      .DIV_W (DIV_W)
   ) u_acc (
      .clk     (clk),
      .rst     (rst),
      .en      (clamp_en),
      .pix     (pix),
      .lvl     (lvl_q),
      .st      (st),
      .upd_div (upd_div),
      .fire    (fire),
      .total   (total)
   );

   obc_corr #(
      .LVL_W (LVL_W),
      .DAC_W (DAC_W),
      .ACC_W (ACC_W),
      .SHIFT (SHIFT)
   ) u_corr (
      .clk   (clk),
      .rst   (rst),
      .en    (clamp_en),
      .lvl   (lvl_q),
      .fire  (fire),
      .total (total),
      .code  (dac_code)
   );

endmodule

// File: tb/black_clamp_loop_tb.sv
`timescale 1ns/1ps
module black_clamp_loop_tb;
   logic        clk = 1'b0;
   logic        rst;
   logic [11:0] pix;
   logic        win_in, win_pol, clamp_en, lvl_we;
   logic [7:0]  lvl_in;
   logic [3:0]  upd_div;
   logic [7:0]  dac_code;

   int n_chk = 0, n_bad = 0;
   int m_lvl, m_corr, m_span, m_n, m_div;
   int unsigned seed_set;
   bit finished = 0;

   always #2.5 clk = ~clk;

   black_clamp_loop u_dut (
      .clk(clk), .rst(rst), .pix(pix), .win_in(win_in), .win_pol(win_pol),
      .clamp_en(clamp_en), .lvl_we(lvl_we), .lvl_in(lvl_in),
      .upd_div(upd_div), .dac_code(dac_code)
   );

   task automatic tick(); @(negedge clk); endtask

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int sat8(int v);
      if (v < 0) return 0;
      if (v > 255) return 255;
      return v;
   endfunction

   function automatic int rpix(int base, int sp);
      int v = base + int'($urandom_range(0, 2 * sp)) - sp;
      if (v < 0) v = 0;
      if (v > 4095) v = 4095;
      return v;
   endfunction

   // Inactive window level for the current polarity
   function automatic logic idle_lvl(); return ~win_pol; endfunction

   // Run one window of len samples near base, then check the result (R4, R5, R6, R8)
   task automatic run_window(int len, int base, int sp, string req);
      int sum = 0;
      for (int i = 0; i < len; i++) begin
         win_in = win_pol;
         pix = 12'(rpix(base, sp));
         sum += int'(pix) - m_lvl;
         tick();
      end
      win_in = idle_lvl();
      pix = 12'($urandom_range(0, 4095));
      tick();
      if (len >= 2) begin
         if (m_n >= m_div) begin
            m_corr = sat8(m_corr + ((m_span + sum) >>> 4));
            m_span = 0; m_n = 0;
         end else begin
            m_span += sum; m_n++;
         end
      end
      check(req, dac_code, m_corr);
   endtask

   // R3: out-of-window samples must not move the output
   task automatic idle(int cyc);
      for (int i = 0; i < cyc; i++) begin
         win_in = idle_lvl();
         pix = 12'($urandom_range(0, 4095));
         tick();
      end
      check("R3", dac_code, m_corr);
   endtask

   task automatic set_div(int d);
      upd_div = 4'(d); m_div = d;
   endtask

   task automatic disable_loop();
      clamp_en = 1'b0; tick(); tick();
      m_corr = m_lvl; m_span = 0; m_n = 0;
      check("R2 R9 disabled output", dac_code, m_lvl);
      clamp_en = 1'b1;
   endtask

   task automatic finish_up();
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   endtask

   initial begin
      #(5.0 * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
   end

   initial begin
      seed_set = $urandom(32'd2718);
      rst = 1'b1; pix = '0; win_pol = 1'b1; win_in = 1'b0; clamp_en = 1'b1;
      lvl_we = 1'b0; lvl_in = '0; set_div(0);
      m_lvl = 128; m_corr = 128; m_span = 0; m_n = 0;
      repeat (3) tick();
      rst = 1'b0;
      tick();
      check("R1 reset code", dac_code, 128);
      // R1: reset target shows through when the loop is off
      disable_loop();
      idle(3);

      // R4: +16 per pixel over 20 pixels -> +20
      run_window(20, 144, 0, "R4 positive update");
      idle(4);
      // R5: low saturation
      run_window(20, 0, 0, "R5 floor");
      idle(2);
      // R5: high saturation
      run_window(20, 4095, 0, "R5 ceiling");
      idle(2);

      disable_loop();
      // R6: one-sample window discarded
      run_window(1, 0, 0, "R6 short window");
      idle(2);
      // R6: two-sample window accepted, +10
      run_window(2, 208, 0, "R6 minimum window");
      check("R6 value", dac_code, 138);
      idle(2);

      // R10: target write while enabled does not move the output
      lvl_we = 1'b1; lvl_in = 8'd64; tick(); lvl_we = 1'b0; tick();
      m_lvl = 64;
      check("R10 write while enabled", dac_code, m_corr);
      run_window(10, 96, 0, "R10 new reference");

      // R7: active-low window
      win_pol = 1'b0; win_in = 1'b1; tick();
      idle(3);
      run_window(10, 96, 0, "R7 active low");
      idle(2);
      win_pol = 1'b1; win_in = 1'b0; tick();

      // R8: update every second window
      set_div(1);
      run_window(12, 96, 0, "R8 held window");
      idle(2);
      run_window(12, 32, 0, "R8 combined update");
      idle(2);

      // R9: disabling mid-span drops the partial sum
      run_window(15, 200, 0, "R9 partial");
      disable_loop();
      run_window(8, 120, 0, "R9 restart first");
      idle(2);
      run_window(8, 10, 0, "R9 restart second");
      idle(2);

      // Random lines
      for (int k = 0; k < 80; k++) begin
         int r = int'($urandom_range(0, 9));
         if (r == 0) set_div(int'($urandom_range(0, 2)));
         else if (r == 1) begin
            lvl_we = 1'b1; lvl_in = 8'($urandom_range(0, 255)); tick(); lvl_we = 1'b0;
            m_lvl = int'(lvl_in); tick();
            check("R10 random write", dac_code, m_corr);
         end else if (r == 2) begin
            win_pol = ~win_pol; win_in = ~win_pol; tick();
         end else if (r == 3) disable_loop();
         run_window(int'($urandom_range(0, 30)), m_lvl + int'($urandom_range(0, 120)) - 60,
                    40, "R4 R8 random line");
         idle(int'($urandom_range(1, 6)));
      end
      finish_up();
   end
endmodule